// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block steers request lines from an add-in card's on-board logic onto the request lines of an ISA bus. Each on-board interrupt source carries its own enable bit and a 3-bit line-select field. A single on-board DMA request can be sent to either of two ISA DMA channels. The active-low acknowledge from the chosen channel is returned to the on-board logic. The configuration is supplied as static inputs. A host-side register file loads it and holds it steady.

A 2-bit mode field decides the meaning of the shared pins. Mode 00 is DMA mode and mode 01 is extended interrupt mode. In DMA mode the two upper bus outputs are DMA requests and the card acknowledge output is driven. In extended interrupt mode the two upper bus outputs become interrupt lines 6 and 7. In that mode the second interrupt input, the DMA request input and both acknowledge inputs are re-read as address bits 15..12, and the acknowledge output pin is released so it can serve as a chip select. Every input passes through one register stage, and every output is a combinational function of those registers.

The block has no data stream, so it has no valid/ready handshake and no back-pressure. All pins are plain level signals.

Top module: `irq_dma_router`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the router behaves as though all enables are clear and the mode is 00. `isa_irq` and `isa_drq_irq67` are 0, `brd_dack_n` is 1, `brd_dack_oe` is 1 and `sa_hi` is 0.
- R2: Mode values 10 and 11 are reserved. In a reserved mode, `isa_irq` and `isa_drq_irq67` are 0, `brd_dack_n` is 1, `brd_dack_oe` is 0 and `sa_hi` is 0.
- R3: In mode 00, an enabled interrupt source whose select value s is in 0..5 drives `isa_irq[s]` with its input level. A select value of 6 or 7 drives no line.
- R4: A source whose enable bit is 0 asserts no output line, whatever its input level.
- R5: When two enabled sources select the same line, that line is the OR of their inputs.
- R6: In mode 00 with `cfg_drq_en`=1, `isa_drq_irq67[cfg_drq_sel]` follows `brd_drq_sa15` and the other channel stays 0. With `cfg_drq_en`=0, both channels are 0.
- R7: In mode 00, `brd_dack_oe` is 1. `brd_dack_n` equals `isa_dack_n_sa12[cfg_drq_sel]` when `cfg_drq_en`=1, and is 1 when `cfg_drq_en`=0.
- R8: In mode 01, source 0 (`brd_irq0`) may select any line 0..7. Lines 6 and 7 appear on `isa_drq_irq67[0]` and `isa_drq_irq67[1]`. Source 1 and the DMA request are never routed in this mode.
- R9: In mode 01, `sa_hi` is {`brd_drq_sa15`, `brd_irq1_sa14`, `isa_dack_n_sa12[1]`, `isa_dack_n_sa12[0]`}, which are address bits 15, 14, 13 and 12. In every other mode `sa_hi` is 0.
- R10: In mode 01, `brd_dack_oe` is 0 and `brd_dack_n` is 1.
- R11: Every output reflects the inputs and configuration sampled at the most recent rising clock edge. A change therefore shows one clock later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 00 selects DMA mode, 01 selects extended interrupt mode, 10 and 11 are reserved |
| cfg_irq_en | input | 2 | Enable bit for each interrupt source |
| cfg_irq0_sel | input | 3 | Line select for source 0 |
| cfg_irq1_sel | input | 3 | Line select for source 1 |
| cfg_drq_en | input | 1 | DMA request routing enable |
| cfg_drq_sel | input | 1 | ISA DMA channel select |
| brd_irq0 | input | 1 | On-board interrupt 0 |
| brd_irq1_sa14 | input | 1 | On-board interrupt 1, or address bit 14 in mode 01 |
| brd_drq_sa15 | input | 1 | On-board DMA request, or address bit 15 in mode 01 |
| isa_dack_n_sa12 | input | 2 | ISA acknowledges (active low), or address bits 13:12 in mode 01 |
| isa_irq | output | 6 | ISA interrupt lines 0..5 |
| isa_drq_irq67 | output | 2 | ISA DMA requests, or interrupt lines 6 and 7 in mode 01 |
| brd_dack_n | output | 1 | Active-low acknowledge to on-board logic |
| brd_dack_oe | output | 1 | Drive enable for the acknowledge pin; 0 releases it for use as a chip select |
| sa_hi | output | 4 | Address bits 15..12 recovered in mode 01 |

## Verification
Every result is due exactly one rising edge after its stimulus, because inputs and configuration both pass through one register. The bench applies each stimulus on a falling edge and compares the outputs on the next falling edge. By then one rising edge has elapsed, and the expected value is computed from the applied stimulus alone. For R11, a directed case also samples 1 ns after a change, before the rising edge, and requires the old value to still be present.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int N_SRC   = 2;
  localparam int N_BASE  = 6;
  localparam int N_CH    = 2;
  localparam int N_LINES = N_BASE + N_CH;
  localparam int SEL_W   = $clog2(N_LINES);
  localparam int CH_W    = $clog2(N_CH);

  localparam logic [1:0] MODE_DMA  = 2'b00;
  localparam logic [1:0] MODE_XIRQ = 2'b01;

  typedef struct packed {
    logic [1:0]                  mode;
    logic [N_SRC-1:0]            irq_en;
    logic [N_SRC-1:0][SEL_W-1:0] irq_sel;
    logic                        drq_en;
    logic [CH_W-1:0]             drq_sel;
  } rtr_cfg_t;

  typedef struct packed {
    logic            drq_a15;
    logic            irq1_a14;
    logic [N_CH-1:0] dack_n_a;
    logic            irq0;
  } rtr_pin_t;

  localparam rtr_pin_t PIN_RST = '{drq_a15: 1'b0, irq1_a14: 1'b0,
                                   dack_n_a: {N_CH{1'b1}}, irq0: 1'b0};
endpackage

// File: rtl/rtr_reg.sv
module rtr_reg #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/rtr_line_mux.sv
module rtr_line_mux #(
  parameter int N_SRC   = 2,
  parameter int N_LINES = 8,
  parameter int SEL_W   = 3
) (
  input  logic [N_SRC-1:0]            req,
  input  logic [N_SRC-1:0]            en,
  input  logic [N_SRC-1:0][SEL_W-1:0] sel,
  input  logic [N_LINES-1:0]          line_ok,
  output logic [N_LINES-1:0]          lines
);
  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin
        if (en[s] && (int'(sel[s]) == k)) acc = acc | req[s];
      end
    end
    assign lines[k] = acc & line_ok[k];
  end
endmodule

// File: rtl/rtr_dma_path.sv
module rtr_dma_path #(
  parameter int N_CH = 2,
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dma_mode,
  input  logic            drq_en,
  input  logic [CH_W-1:0] drq_sel,
  input  logic            drq,
  input  logic [N_CH-1:0] dack_n,
  output logic [N_CH-1:0] drq_lines,
  output logic            brd_dack_n
);
  logic granted;
  assign granted = dma_mode & drq_en;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign drq_lines[c] = granted & (int'(drq_sel) == c) & drq;
  end

  assign brd_dack_n = granted ? dack_n[drq_sel] : 1'b1;

  // R6
  drq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drq_lines));

  // R7
  dack_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brd_dack_n |-> (dma_mode && drq_en));
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import rtr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic [N_SRC-1:0]    cfg_irq_en,
  input  logic [SEL_W-1:0]    cfg_irq0_sel,
  input  logic [SEL_W-1:0]    cfg_irq1_sel,
  input  logic                cfg_drq_en,
  input  logic [CH_W-1:0]     cfg_drq_sel,
  input  logic                brd_irq0,
  input  logic                brd_irq1_sa14,
  input  logic                brd_drq_sa15,
  input  logic [N_CH-1:0]     isa_dack_n_sa12,
  output logic [N_BASE-1:0]   isa_irq,
  output logic [N_CH-1:0]     isa_drq_irq67,
  output logic                brd_dack_n,
  output logic                brd_dack_oe,
  output logic [3:0]          sa_hi
);
  localparam int CFG_W = $bits(rtr_cfg_t);
  localparam int PIN_W = $bits(rtr_pin_t);

  rtr_cfg_t cfg_d, cfg_q;
  rtr_pin_t pin_d, pin_q;

  assign cfg_d = '{mode: cfg_mode, irq_en: cfg_irq_en,
                   irq_sel: {cfg_irq1_sel, cfg_irq0_sel},
                   drq_en: cfg_drq_en, drq_sel: cfg_drq_sel};
  assign pin_d = '{drq_a15: brd_drq_sa15, irq1_a14: brd_irq1_sa14,
                   dack_n_a: isa_dack_n_sa12, irq0: brd_irq0};

  rtr_reg #(.W(CFG_W), .RST_VAL('0)) u_cfg_reg (
    .clk(clk), .rst_n(rst_n), .d(cfg_d), .q(cfg_q));

  rtr_reg #(.W(PIN_W), .RST_VAL(PIN_RST)) u_pin_reg (
    .clk(clk), .rst_n(rst_n), .d(pin_d), .q(pin_q));

  logic dma_mode, xirq_mode;
  assign dma_mode  = (cfg_q.mode == MODE_DMA);
  assign xirq_mode = (cfg_q.mode == MODE_XIRQ);

  // In extended interrupt mode only source 0 keeps a real pin.
  localparam logic [N_SRC-1:0] XIRQ_SRC_MASK = {{(N_SRC-1){1'b0}}, 1'b1};
  localparam logic [N_LINES-1:0] DMA_LINE_OK = {{N_CH{1'b0}}, {N_BASE{1'b1}}};

  logic [N_SRC-1:0]   src_en;
  logic [N_SRC-1:0]   src_req;
  logic [N_LINES-1:0] line_ok;
  logic [N_LINES-1:0] irq_lines;
  logic [N_CH-1:0]    drq_lines;
  logic               dack_n_int;

  always_comb begin
    src_en  = '0;
    line_ok = '0;
    if (dma_mode) begin
      src_en  = cfg_q.irq_en;
      line_ok = DMA_LINE_OK;
    end else if (xirq_mode) begin
      src_en  = cfg_q.irq_en & XIRQ_SRC_MASK;
      line_ok = '1;
    end
  end

  assign src_req = {pin_q.irq1_a14, pin_q.irq0};

  rtr_line_mux #(.N_SRC(N_SRC), .N_LINES(N_LINES), .SEL_W(SEL_W)) u_line_mux (
    .req(src_req), .en(src_en), .sel(cfg_q.irq_sel),
    .line_ok(line_ok), .lines(irq_lines));

  rtr_dma_path #(.N_CH(N_CH), .CH_W(CH_W)) u_dma_path (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
    .drq_en(cfg_q.drq_en), .drq_sel(cfg_q.drq_sel), .drq(pin_q.drq_a15),
    .dack_n(pin_q.dack_n_a), .drq_lines(drq_lines), .brd_dack_n(dack_n_int));

  assign isa_irq       = irq_lines[N_BASE-1:0];
  assign isa_drq_irq67 = irq_lines[N_LINES-1:N_BASE] | drq_lines;
  assign brd_dack_n    = dack_n_int;
  assign brd_dack_oe   = dma_mode;
  assign sa_hi         = xirq_mode ? {pin_q.drq_a15, pin_q.irq1_a14, pin_q.dack_n_a}
                                   : 4'b0000;

  // R4
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.irq_en == '0 && !cfg_q.drq_en) |-> (isa_irq == '0 && isa_drq_irq67 == '0));

  // R2
  rsv_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode[1]) |-> (isa_irq == '0 && isa_drq_irq67 == '0 && brd_dack_n && !brd_dack_oe));

  // R10
  xirq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xirq_mode |-> (!brd_dack_oe && brd_dack_n));

  // R9
  sa_hi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xirq_mode |-> (sa_hi == 4'b0000));
endmodule

// File: tb/irq_dma_router_tb.sv
module irq_dma_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] mode = 2'b00;
  logic [1:0] en = 2'b00;
  logic [2:0] s0 = 3'd0, s1 = 3'd0;
  logic den = 1'b0, dsel = 1'b0;
  logic i0 = 1'b0, i1 = 1'b0, drq = 1'b0;
  logic [1:0] dk = 2'b11;

  logic [5:0] isa_irq;
  logic [1:0] isa_drq_irq67;
  logic brd_dack_n, brd_dack_oe;
  logic [3:0] sa_hi;

  int checks = 0, fails = 0;
  bit finished = 0;

  irq_dma_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_irq_en(en),
    .cfg_irq0_sel(s0), .cfg_irq1_sel(s1), .cfg_drq_en(den), .cfg_drq_sel(dsel),
    .brd_irq0(i0), .brd_irq1_sa14(i1), .brd_drq_sa15(drq), .isa_dack_n_sa12(dk),
    .isa_irq(isa_irq), .isa_drq_irq67(isa_drq_irq67), .brd_dack_n(brd_dack_n),
    .brd_dack_oe(brd_dack_oe), .sa_hi(sa_hi));

  // {irq8, dack_n, oe, sa_hi}
  function automatic logic [13:0] model();
    logic [7:0] irq8 = '0;
    logic dkn = 1'b1, oe = 1'b0;
    logic [3:0] a = '0;
    if (mode == 2'b00) begin
      oe = 1'b1;
      if (en[0] && s0 < 3'd6) irq8[s0] = irq8[s0] | i0;
      if (en[1] && s1 < 3'd6) irq8[s1] = irq8[s1] | i1;
      if (den) begin
        irq8[6 + int'(dsel)] = drq;
        dkn = dk[dsel];
      end
    end else if (mode == 2'b01) begin
      if (en[0]) irq8[s0] = i0;
      a = {drq, i1, dk};
    end
    return {irq8, dkn, oe, a};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [13:0] e = model();
    check({tag, " irq"}, {26'd0, isa_irq}, {26'd0, e[11:6]});
    check({tag, " drq/irq67"}, {30'd0, isa_drq_irq67}, {30'd0, e[13:12]});
    check({tag, " dack_n"}, {31'd0, brd_dack_n}, {31'd0, e[5]});
    check({tag, " dack_oe"}, {31'd0, brd_dack_oe}, {31'd0, e[4]});
    check({tag, " sa_hi"}, {28'd0, sa_hi}, {28'd0, e[3:0]});
  endtask

  function automatic string mtag();
    if (mode == 2'b00) return "R3 R5 R6 R7 R9";
    if (mode == 2'b01) return "R8 R9 R10";
    return "R2";
  endfunction

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    mode = 2'b01; en = 2'b11; s0 = 3'd2; s1 = 3'd3; den = 1'b1;
    i0 = 1'b1; i1 = 1'b1; drq = 1'b1; dk = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {26'd0, isa_irq}, 32'd0);
    check("R1 drq", {30'd0, isa_drq_irq67}, 32'd0);
    check("R1 dack_n", {31'd0, brd_dack_n}, 32'd1);
    check("R1 dack_oe", {31'd0, brd_dack_oe}, 32'd1);
    check("R1 sa_hi", {28'd0, sa_hi}, 32'd0);
    rst_n = 1'b1;
    mode = 2'b00; en = 2'b00; den = 1'b0; i0 = 0; i1 = 0; drq = 0; dk = 2'b11;
    step("R1 post");

    // R3: every select value in DMA mode
    en = 2'b01; i0 = 1'b1;
    for (int k = 0; k < 8; k++) begin
      s0 = 3'(k);
      step("R3 sel");
    end
    // R4: disabled sources with active inputs
    en = 2'b00; i1 = 1'b1; s0 = 3'd1; s1 = 3'd4;
    step("R4 disabled");
    check("R4 no line", {26'd0, isa_irq}, 32'd0);
    // R5: shared line
    en = 2'b11; s0 = 3'd3; s1 = 3'd3;
    i0 = 0; i1 = 1; step("R5 share");
    i0 = 1; i1 = 0; step("R5 share");
    i0 = 0; i1 = 0; step("R5 share");
    check("R5 both low", {26'd0, isa_irq}, 32'd0);
    // R6/R7: DMA routing and acknowledge
    en = 2'b00; den = 1'b1; drq = 1'b1;
    for (int c = 0; c < 2; c++) begin
      dsel = c[0];
      dk = c[0] ? 2'b01 : 2'b10;
      step("R6 R7 chan");
      check("R7 ack", {31'd0, brd_dack_n}, 32'd0);
    end
    den = 1'b0; step("R6 R7 off");
    // R8/R10: extended mode
    mode = 2'b01; en = 2'b11; i0 = 1; i1 = 1; s1 = 3'd0; den = 1'b1; drq = 1'b1;
    s0 = 3'd6; step("R8 line6");
    check("R8 line6", {30'd0, isa_drq_irq67}, 32'd1);
    s0 = 3'd7; step("R8 line7");
    check("R8 irq1 unrouted", {26'd0, isa_irq}, 32'd0);
    // R9: address bits
    i1 = 0; drq = 1; dk = 2'b01; step("R9 addr");
    check("R9 addr", {28'd0, sa_hi}, 32'h9);
    // R2: reserved modes
    mode = 2'b10; step("R2 mode10");
    mode = 2'b11; step("R2 mode11");
    // R11: change is not visible before the rising edge
    mode = 2'b00; en = 2'b01; s0 = 3'd2; i0 = 1'b0; den = 1'b0;
    step("R11 base");
    i0 = 1'b1;
    #1;
    check("R11 early", {26'd0, isa_irq}, 32'd0);
    step("R11 after edge");
    check("R11 late", {26'd0, isa_irq}, 32'h4);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] r = 3'($urandom_range(0, 7));
      mode = (r == 3'd7) ? 2'($urandom_range(2, 3)) : {1'b0, r[0]};
      en = 2'($urandom); s0 = 3'($urandom); s1 = 3'($urandom);
      den = 1'($urandom); dsel = 1'($urandom);
      i0 = 1'($urandom); i1 = 1'($urandom); drq = 1'($urandom); dk = 2'($urandom);
      step(mtag());
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule